// File: doc/BRIEF.md
# Fused Compound-Operation Integer ALU

This block is a 32-bit integer execution unit in which one opcode performs two dependent operations back to back, the second consuming the first's result. It covers the patterns that dominate hash-round arithmetic:
- a bit-select built from XOR, AND and XOR;
- a three-operand sum;
- a funnel right shift across two registers, which becomes a rotate when both registers hold the same value;
- that funnel shift followed by an accumulate into the destination's previous value;
- a three-operand sum followed by a left rotate.

A hash step that would otherwise take a dozen simple instructions shrinks to a handful.

Each operation arrives as one transfer on a valid/ready input channel. The transfer carries a 3-bit opcode, the destination's previous value, two source operands and a 5-bit shift amount. The result leaves one cycle later on a valid/ready output channel through a single result register.

Back-pressure rules:
- An input transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the result register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the held result does not change and no new operation is taken.

The producer may present a new operation on every cycle. Full throughput therefore needs the consumer to hold `out_ready` high.

Top module: `fused_alu`

## Requirements
- R1: Opcode 1 (bit-select) returns ((dst ^ src1) & src2) ^ dst. Each result bit equals src1 where src2 is 1 and dst where src2 is 0.
- R2: Opcode 2 (triple add) returns dst + src1 + src2, wrapped modulo 2^32, with no flags.
- R3: Opcode 3 (funnel shift) returns bits [31+n:n] of the 64-bit value {src1, src2}, where n is the 5-bit amount. For n = 0 it returns src2 unchanged.
- R4: When src1 equals src2, opcode 3 gives src2 rotated right by n. This is the same as a left rotate by 32 - n.
- R5: Opcode 4 (funnel shift then accumulate) returns the R3 result plus dst, wrapped modulo 2^32.
- R6: Opcode 5 (add then rotate) returns (dst + src1 + src2) rotated left by n, with the sum wrapped modulo 2^32. For n = 0 it returns the plain sum.
- R7: Opcodes 0, 6 and 7 return zero.
- R8: An input accepted on a clock edge shows its result on `out_result`, with `out_valid` high, right after that same edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_result` holds, `in_ready` is low, and any operation presented on the input does not change the held result.
- R10: While reset is asserted and after it is released, `out_valid` is low and `out_result` is zero until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the input channel |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 3 | Opcode: 1 select, 2 add3, 3 funnel, 4 funnel+acc, 5 add+rotate |
| in_dst | input | 32 | Previous value of the destination |
| in_src1 | input | 32 | First source; high word of the funnel shift |
| in_src2 | input | 32 | Second source; low word of the funnel shift, select mask |
| in_amt | input | 5 | Shift or rotate amount |
| out_valid | output | 1 | Result register holds an unread result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result of the accepted operation |

## Verification
Any fault in the operation datapath appears at `out_result` right after the edge that accepted the faulty operation, because one register stands between input and output. A corrupted valid or hold state appears as a result that changes, or a valid that drops, during a stalled cycle. It can also appear as `in_ready` rising while the output is blocked. All of these are visible within one cycle of the stall starting. Faults that only matter at boundaries show up only for specific stimuli. A shift amount of zero, rotates with equal sources, wrap-around sums and the unused opcodes are therefore each driven explicitly.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 3'd0,
    OP_BSEL    = 3'd1,
    OP_ADD3    = 3'd2,
    OP_FSHR    = 3'd3,
    OP_FSHR_AC = 3'd4,
    OP_ADD_ROT = 3'd5
  } op_code_e;
endpackage

// File: rtl/fca_add3.sv
module fca_add3 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  // Modulo 2^W sum; carries beyond bit W-1 are dropped.
  always_comb y_o = a_i + b_i + c_i;
endmodule

// File: rtl/fca_funnel.sv
module fca_funnel #(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     hi_i,
  input  logic [W-1:0]     lo_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     res_o
);
  logic [2*W-1:0] cat;

  always_comb begin
    cat = {hi_i, lo_i};
    for (int i = 0; i < W; i++) begin
      res_o[i] = cat[i + int'(amt_i)];
    end
  end

  always_comb begin
    if (amt_i == '0) begin
      AST_ZERO_SHIFT: assert (res_o == lo_i); // R3
    end
    if (hi_i == lo_i) begin
      AST_SAME_ROTATE: assert (res_o == ((lo_i >> amt_i) | (lo_i << (W - int'(amt_i))))); // R4
    end
  end
endmodule

// File: rtl/fca_exec.sv
module fca_exec
  import fused_alu_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     s1_i,
  input  logic [W-1:0]     s2_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     res_o
);
  logic [W-1:0]     sum3;
  logic [W-1:0]     fun_hi, fun_lo, fun_res, acc;
  logic [AMT_W-1:0] fun_amt;
  logic             rot_sel;

  fca_add3 #(.W(W)) u_sum3 (
    .a_i(dst_i), .b_i(s1_i), .c_i(s2_i), .y_o(sum3)
  );

  // One shifter serves both the funnel forms and the rotate-after-add form;
  // a left rotate by n is a right funnel of (x, x) by (-n mod W).
  always_comb begin
    rot_sel = (op_i == OP_ADD_ROT);
    fun_hi  = rot_sel ? sum3 : s1_i;
    fun_lo  = rot_sel ? sum3 : s2_i;
    fun_amt = rot_sel ? (~amt_i + AMT_W'(1)) : amt_i;
  end

  fca_funnel #(.W(W), .AMT_W(AMT_W)) u_funnel (
    .hi_i(fun_hi), .lo_i(fun_lo), .amt_i(fun_amt), .res_o(fun_res)
  );

  fca_add3 #(.W(W)) u_acc (
    .a_i(fun_res), .b_i(dst_i), .c_i('0), .y_o(acc)
  );

  always_comb begin
    case (op_i)
      OP_BSEL:    res_o = ((dst_i ^ s1_i) & s2_i) ^ dst_i;
      OP_ADD3:    res_o = sum3;
      OP_FSHR:    res_o = fun_res;
      OP_FSHR_AC: res_o = acc;
      OP_ADD_ROT: res_o = fun_res;
      default:    res_o = '0;
    endcase
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fused_alu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [DATA_W-1:0]   in_dst,
  input  logic [DATA_W-1:0]   in_src1,
  input  logic [DATA_W-1:0]   in_src2,
  input  logic [AMT_W-1:0]    in_amt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_result
);
  logic [DATA_W-1:0] exec_res;
  logic              take;

  fca_exec #(.W(DATA_W), .AMT_W(AMT_W)) u_exec (
    .op_i(in_op), .dst_i(in_dst), .s1_i(in_src1), .s2_i(in_src2),
    .amt_i(in_amt), .res_o(exec_res)
  );

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= exec_res;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 3'd0 || in_op == 3'd6 || in_op == 3'd7)
    |=> out_result == '0); // R7

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid && out_result == '0); // R10
endmodule

// File: tb/fused_alu_tb.sv
module fused_alu_tb_top;
  localparam int NV = 18;

  localparam logic [2:0]  V_OP  [NV] = '{3'd1, 3'd1, 3'd1, 3'd2, 3'd2, 3'd2,
    3'd3, 3'd3, 3'd3, 3'd3, 3'd4, 3'd4, 3'd5, 3'd5, 3'd5, 3'd0, 3'd6, 3'd7};
  localparam logic [31:0] V_D   [NV] = '{32'h0000FFFF, 32'h12345678, 32'h12345678,
    32'h00000001, 32'hFFFFFFFF, 32'h80000000, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h00000010, 32'hFFFFFFFF, 32'h80000000, 32'h00000005, 32'hFFFFFFFF,
    32'hDEADBEEF, 32'h11111111, 32'h22222222};
  localparam logic [31:0] V_S1  [NV] = '{32'hFFFF0000, 32'h9ABCDEF0, 32'h9ABCDEF0,
    32'h00000002, 32'h00000001, 32'h80000000, 32'h11223344, 32'h11223344,
    32'h00000001, 32'h80000001, 32'h0000000F, 32'h00000000, 32'h00000001,
    32'h00000006, 32'h00000001, 32'h12345678, 32'h33333333, 32'h44444444};
  localparam logic [31:0] V_S2  [NV] = '{32'h00FF00FF, 32'h00000000, 32'hFFFFFFFF,
    32'h00000003, 32'h00000000, 32'h80000000, 32'h55667788, 32'h55667788,
    32'h80000000, 32'h80000001, 32'h0000000F, 32'h00000002, 32'h00000000,
    32'h00000007, 32'h0000000F, 32'h9ABCDEF0, 32'h55555555, 32'h66666666};
  localparam logic [4:0]  V_AMT [NV] = '{5'd0, 5'd3, 5'd7, 5'd0, 5'd9, 5'd1,
    5'd8, 5'd0, 5'd31, 5'd1, 5'd4, 5'd1, 5'd4, 5'd0, 5'd28, 5'd5, 5'd6, 5'd7};
  localparam logic [31:0] V_EXP [NV] = '{32'h00FFFF00, 32'h12345678, 32'h9ABCDEF0,
    32'h00000006, 32'h00000000, 32'h80000000, 32'h44556677, 32'h55667788,
    32'h00000003, 32'hC0000000, 32'hF0000010, 32'h00000000, 32'h00000018,
    32'h00000012, 32'hF0000000, 32'h0, 32'h0, 32'h0};
  localparam string V_REQ [NV] = '{"R1", "R1", "R1", "R2", "R2", "R2",
    "R3", "R3", "R3", "R4", "R5", "R5", "R6", "R6", "R6", "R7", "R7", "R7"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [4:0]  in_amt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fused_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_amt(in_amt), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] d,
                       input logic [31:0] s1, input logic [31:0] s2,
                       input logic [4:0] n);
    in_op = op; in_dst = d; in_src1 = s1; in_src2 = s2; in_amt = n;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "valid in reset", {31'b0, out_valid}, 32'h0);
    check("R10", "result in reset", out_result, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", "valid after release", {31'b0, out_valid}, 32'h0);
    check("R10", "result after release", out_result, 32'h0);

    // Vector table, one operation per cycle.
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(V_OP[k], V_D[k], V_S1[k], V_S2[k], V_AMT[k]);
      in_valid = 1'b1;
      @(posedge clk); #1;
      check(V_REQ[k], "vector result", out_result, V_EXP[k]);
      check("R8", "valid after accept", {31'b0, out_valid}, 32'h1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R8", "valid drops when idle", {31'b0, out_valid}, 32'h0);

    // Back-pressure: R9
    @(negedge clk);
    out_ready = 1'b0;
    drive(3'd2, 32'd1, 32'd2, 32'd3, 5'd0);
    in_valid = 1'b1;
    @(posedge clk); #1;
    check("R9", "first result", out_result, 32'd6);
    check("R9", "in_ready low on stall", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    drive(3'd2, 32'd10, 32'd10, 32'd10, 5'd0);
    @(posedge clk); #1;
    check("R9", "held result", out_result, 32'd6);
    check("R9", "held valid", {31'b0, out_valid}, 32'h1);
    @(posedge clk); #1;
    check("R9", "still held", out_result, 32'd6);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    check("R9", "next after release", out_result, 32'd30);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R9", "drained", {31'b0, out_valid}, 32'h0);
    check("R9", "result kept after drain", out_result, 32'd30);

    // Funnel corner: n = 0 on the accumulate form returns src2 + dst (R5, R3)
    @(negedge clk);
    drive(3'd4, 32'h00000100, 32'hFFFFFFFF, 32'h00000023, 5'd0);
    in_valid = 1'b1;
    @(posedge clk); #1;
    check("R5", "funnel acc n=0", out_result, 32'h00000123);
    @(negedge clk);
    drive(3'd3, 32'h0, 32'hA5A5A5A5, 32'hA5A5A5A5, 5'd31);
    @(posedge clk); #1;
    check("R4", "rotate right 31", out_result, 32'h4B4B4B4B);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule